// File: doc/BRIEF.md
# Steerable Interrupt Controller

This block gathers a word of independent interrupt lines. Software sets, for each line, whether it is level-sensitive or edge-triggered and which level or edge counts as active. A line that becomes active sets a sticky pending bit. Software clears a pending bit by writing a one to it.

The pending bits are gated by a per-line enable and then steered to one of two registered processor outputs: an urgent (critical) line or an ordinary line. A small resolver, also registered, names one pending enabled line so a handler can service it without scanning.

One input position can also be driven by the ordinary output of a downstream controller of the same kind. For that to work, the position must be programmed level-sensitive. Acknowledging a downstream line then takes two writes: clear it at the downstream controller, then clear the cascade position here.

All configuration and status live behind a word-wide register port. Reads return data one cycle after the address is presented. Writes take effect on the clock edge where the write enable is high.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Line number n (0..31) is bit 31-n of `irq_in` and of every per-line register, so line 0 is the most significant bit.
- R2: After reset, the pending, enable and urgent-select registers read zero, and the polarity and trigger registers read all ones. Both interrupt outputs are low and the resolver flags "none".
- R3: Writing to offset 0x00 clears each pending bit written as 1 and leaves bits written as 0 unchanged; writing all ones clears every pending bit.
- R4: A line with trigger bit 0 is level-sensitive and its pending bit is set while its input is at the active level. Clearing it while the input stays active leaves it pending again one cycle later.
- R5: A line with trigger bit 1 sets its pending bit once per active edge. Polarity bit 1 selects the rising edge or high level, and polarity bit 0 selects the falling edge or low level. A cleared edge line stays clear until the next active edge.
- R6: Offset 0x14 reads pending AND enable. Clearing an enable bit removes the line from the outputs but keeps its pending bit.
- R7: Urgent-select bit 1 routes a pending enabled line to `irq_crit_o`; bit 0 routes it to `irq_norm_o`. With the register at zero, only `irq_norm_o` can assert.
- R8: An input change sets pending on the third rising edge after it is driven (two-stage synchronizer, then the pending register). The output follows on the fourth.
- R9: `pend_id_o` gives the line number held in the lowest-order set bit of the masked pending word, which is the highest-numbered line. `pend_none_o` is 1 when the masked word is zero. Both outputs are registered.
- R10: If a clear write lands on the same edge as a new active edge of an edge-triggered line, the line remains pending.
- R11: `casc_in` is ORed into the input of the line chosen by parameter CASC_SRC (default 31, bit 0) ahead of the synchronizer.
- R12: The register map is 0x00 pending, 0x04 enable, 0x08 urgent select, 0x0C polarity, 0x10 trigger, 0x14 masked pending (read-only). Writes to 0x14 have no effect, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt lines, line n on bit 31-n |
| casc_in | input | 1 | Ordinary output of a downstream controller |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the previous cycle's offset |
| irq_norm_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Urgent interrupt request |
| pend_id_o | output | 5 | Resolved pending line number |
| pend_none_o | output | 1 | No enabled line is pending |

## Verification
A software clear and a freshly detected edge can hit the same pending bit on one clock edge. The bench provokes this by raising the line and timing the clear write so that it lands exactly on the edge where the synchronized rising edge is registered. The bit must still read as pending afterwards, while an identical clear with no new edge must leave it at zero. A level line cleared while still active is judged by reading it back as pending again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_PEND = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_EN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_URG  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_POL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 5'h14;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] trig_i,
  output logic [NSRC-1:0] lvl_set_o,
  output logic [NSRC-1:0] edg_set_o
);
  logic [NSRC-1:0] stg [STAGES];
  logic [NSRC-1:0] act;
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  // polarity applied before edge compare: 1 = high/rising, 0 = low/falling
  assign act = ~(stg[STAGES-1] ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= act;
  end

  assign lvl_set_o = act & ~trig_i;
  assign edg_set_o = act & ~prev_q & trig_i;

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (edg_set_o & $past(edg_set_o)) == '0);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   lvl_set_i,
  input  logic [NSRC-1:0]   edg_set_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   urg_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   trig_o,
  output logic [NSRC-1:0]   rdata_o
);
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] pend_n;

  // clear beats a level set (it re-sets next cycle); an edge set beats the clear
  assign clr    = (we_i && addr_i == OFF_PEND) ? wdata_i : '0;
  assign pend_n = (pend_o & ~clr) | (lvl_set_i & ~clr) | edg_set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      en_o   <= '0;
      urg_o  <= '0;
      pol_o  <= '1;
      trig_o <= '1;
    end else begin
      pend_o <= pend_n;
      if (we_i) begin
        unique case (addr_i)
          OFF_EN:   en_o   <= wdata_i;
          OFF_URG:  urg_o  <= wdata_i;
          OFF_POL:  pol_o  <= wdata_i;
          OFF_TRIG: trig_o <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      unique case (addr_i)
        OFF_PEND: rdata_o <= pend_o;
        OFF_EN:   rdata_o <= en_o;
        OFF_URG:  rdata_o <= urg_o;
        OFF_POL:  rdata_o <= pol_o;
        OFF_TRIG: rdata_o <= trig_o;
        OFF_MSK:  rdata_o <= pend_o & en_o;
        default:  rdata_o <= '0;
      endcase
    end
  end

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == OFF_PEND) |=> (pend_o & $past(wdata_i & ~edg_set_i)) == '0);
  // R2
  reset_cfg_chk: assert property (@(posedge clk)
    rst |=> (pol_o == '1 && trig_o == '1 && pend_o == '0 && en_o == '0));
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned ID_W = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] masked_i,
  output logic [ID_W-1:0] id_o,
  output logic            none_o
);
  logic [ID_W-1:0] id_c;

  always_comb begin
    id_c = '0;
    for (int j = NSRC - 1; j >= 0; j--) begin
      if (masked_i[j]) id_c = ID_W'(NSRC - 1 - j);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_o   <= '0;
      none_o <= 1'b1;
    end else begin
      id_o   <= id_c;
      none_o <= (masked_i == '0);
    end
  end

  // R9
  none_empty_chk: assert property (@(posedge clk) disable iff (rst)
    none_o |-> $past(masked_i) == '0);
  // R9
  some_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    !none_o |-> $past(masked_i) != '0);
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned CASC_SRC = 31,
  localparam int unsigned ID_W    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              casc_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_norm_o,
  output logic              irq_crit_o,
  output logic [ID_W-1:0]   pend_id_o,
  output logic              pend_none_o
);
  localparam int unsigned CASC_BIT = NSRC - 1 - CASC_SRC;

  logic [NSRC-1:0] raw, lvl_set, edg_set;
  logic [NSRC-1:0] pend, en, urg, pol, trig, masked;

  for (genvar i = 0; i < NSRC; i++) begin : g_raw
    if (i == CASC_BIT) begin : g_casc
      assign raw[i] = irq_in[i] | casc_in;
    end else begin : g_plain
      assign raw[i] = irq_in[i];
    end
  end

  irqc_detect #(.NSRC(NSRC), .STAGES(STAGES)) detect_i (
    .clk(clk), .rst(rst), .raw_i(raw), .pol_i(pol), .trig_i(trig),
    .lvl_set_o(lvl_set), .edg_set_o(edg_set));

  irqc_regs #(.NSRC(NSRC)) regs_i (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .lvl_set_i(lvl_set), .edg_set_i(edg_set), .pend_o(pend), .en_o(en),
    .urg_o(urg), .pol_o(pol), .trig_o(trig), .rdata_o(reg_rdata));

  assign masked = pend & en;

  irqc_resolve #(.NSRC(NSRC)) resolve_i (
    .clk(clk), .rst(rst), .masked_i(masked), .id_o(pend_id_o), .none_o(pend_none_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_norm_o <= |(masked & ~urg);
      irq_crit_o <= |(masked & urg);
    end
  end

  // R7
  crit_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_crit_o |-> $past(|(pend & en & urg)));
  // R6
  norm_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq_norm_o && !irq_crit_o);
  // R7
  norm_nocrit_chk: assert property (@(posedge clk) disable iff (rst)
    (urg == '1) |=> !irq_norm_o);
endmodule

// File: tb/irq_steer_ctrl_tb_top.sv
module irq_steer_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        casc_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_norm_o, irq_crit_o, pend_none_o;
  logic [4:0]  pend_id_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_steer_ctrl dut_i (.*);

  function automatic logic [31:0] bitof(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic cleanup();
    irq_in = '0; casc_in = 1'b0;
    wr(5'h10, '1); wr(5'h0C, '1); wr(5'h04, '0); wr(5'h08, '0);
    settle(); wr(5'h00, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); chk("R2 pend", v, '0);
    rd(5'h04, v); chk("R2 enable", v, '0);
    rd(5'h08, v); chk("R2 urgent", v, '0);
    rd(5'h0C, v); chk("R2 polarity", v, '1);
    rd(5'h10, v); chk("R2 trigger", v, '1);
    chk("R2 outputs", {pend_none_o, irq_norm_o, irq_crit_o}, 32'b100);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    irq_in = bitof(5); settle(); irq_in = '0; settle();
    rd(5'h00, v); chk("R1 R5 rising edge line 5", v, bitof(5));
    wr(5'h00, 32'h0); rd(5'h00, v); chk("R3 zero write keeps", v, bitof(5));
    wr(5'h00, bitof(5)); rd(5'h00, v); chk("R3 w1c clears", v, '0);
    settle(); rd(5'h00, v); chk("R5 stays clear", v, '0);
    cleanup();
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    irq_in = bitof(7); settle();
    wr(5'h0C, ~bitof(7)); settle(); wr(5'h00, '1);
    rd(5'h00, v); chk("R5 rising ignored when falling", v, '0);
    irq_in = '0; settle();
    rd(5'h00, v); chk("R5 falling edge line 7", v, bitof(7));
    wr(5'h00, '1); rd(5'h00, v); chk("R3 all ones clear", v, '0);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(5'h10, ~bitof(12)); irq_in = bitof(12); settle();
    rd(5'h00, v); chk("R4 level high pending", v, bitof(12));
    wr(5'h00, bitof(12)); settle(); rd(5'h00, v); chk("R4 re-set while active", v, bitof(12));
    irq_in = '0; settle(); wr(5'h00, bitof(12)); settle();
    rd(5'h00, v); chk("R4 clear after release", v, '0);
    wr(5'h0C, ~bitof(12)); settle();
    rd(5'h00, v); chk("R4 active-low pending", v, bitof(12));
    irq_in = bitof(12); settle(); wr(5'h00, bitof(12)); settle();
    rd(5'h00, v); chk("R4 active-low released", v, '0);
    cleanup();
  endtask

  task automatic t_latency();
    wr(5'h04, bitof(5));
    @(negedge clk); irq_in = bitof(5);
    repeat (3) @(negedge clk);
    chk("R8 not yet at edge 3", {31'b0, irq_norm_o}, 32'd0);
    @(negedge clk);
    chk("R8 output at edge 4", {31'b0, irq_norm_o}, 32'd1);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    irq_in = bitof(5); settle(); irq_in = '0;
    rd(5'h14, v); chk("R6 masked zero", v, '0);
    chk("R6 norm off", {31'b0, irq_norm_o}, 32'd0);
    wr(5'h04, bitof(5)); settle();
    rd(5'h14, v); chk("R6 masked", v, bitof(5));
    chk("R7 normal route", {30'b0, irq_norm_o, irq_crit_o}, 32'b10);
    wr(5'h08, bitof(5)); settle();
    chk("R7 urgent route", {30'b0, irq_norm_o, irq_crit_o}, 32'b01);
    wr(5'h04, '0); settle();
    rd(5'h00, v); chk("R6 pending kept", v, bitof(5));
    chk("R6 outputs off", {30'b0, irq_norm_o, irq_crit_o}, 32'b00);
    cleanup();
  endtask

  task automatic t_resolve();
    irq_in = bitof(3) | bitof(10); settle(); irq_in = '0;
    wr(5'h04, bitof(3) | bitof(10)); settle();
    chk("R9 id highest line", {26'b0, pend_none_o, pend_id_o}, {26'b0, 1'b0, 5'd10});
    wr(5'h04, bitof(3)); settle();
    chk("R9 id line 3", {26'b0, pend_none_o, pend_id_o}, {26'b0, 1'b0, 5'd3});
    wr(5'h04, '0); settle();
    chk("R9 none", {31'b0, pend_none_o}, 32'd1);
    cleanup();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    irq_in = bitof(20); settle(); irq_in = '0; settle();
    wr(5'h00, bitof(20)); rd(5'h00, v); chk("R10 plain clear", v, '0);
    irq_in = bitof(20); settle(); irq_in = '0; settle();
    @(negedge clk); irq_in = bitof(20);
    @(negedge clk);
    wr(5'h00, bitof(20));
    rd(5'h00, v); chk("R10 edge beats clear", v, bitof(20));
    cleanup();
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    wr(5'h10, ~32'h1); casc_in = 1'b1; settle();
    rd(5'h00, v); chk("R11 cascade line 31", v, 32'h1);
    casc_in = 1'b0; settle(); wr(5'h00, 32'h1);
    rd(5'h00, v); chk("R11 cascade ack", v, '0);
    cleanup();
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(5'h04, 32'h00F0_0000);
    wr(5'h14, '1); rd(5'h04, v); chk("R12 masked write ignored", v, 32'h00F0_0000);
    rd(5'h00, v); chk("R12 pend untouched", v, '0);
    rd(5'h18, v); chk("R12 unmapped reads zero", v, '0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_edge_rise();
    t_edge_fall();
    t_level();
    t_latency();
    t_mask();
    t_resolve();
    t_collide();
    t_cascade();
    t_map();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule